// File: doc/BRIEF.md
# Rendezvous Channel Fabric with Priority Select

This block joins several sending processes to one receiving process over point-to-point synchronous channels that hold no data of their own. Each channel has exactly one sender. A word crosses a channel only in a clock cycle in which the sender is requesting and the receiver is requesting at the same time. Whichever side arrives first simply keeps its request raised and waits. Completion is reported to both sides as a one-cycle pulse in the cycle of the transfer, and the requester drops or renews its request after that edge.

The receiver does not name a channel. It raises a single receive request, and the priority select front end hands it the word from the ready sender with the lowest channel index. The index of the chosen channel comes back with the data. A sender that is ready but not chosen gets no completion pulse and remains blocked, with its data still presented, until a later cycle picks it.

A small demonstration pair runs beside the fabric from reset. A producer offers a 4-bit count over its own rendezvous channel. It advances the count only when that value has been taken. A consumer takes each value, shows it on four output pins, and then sits out a parameterised number of idle cycles before it asks again.

Top module: `rvzAltTop`

## Requirements
- R1: A transfer on channel i happens in a cycle exactly when `recvReq` is 1, `sendReq[i]` is 1 and no lower-indexed channel is requesting. In that cycle `sendDone[i]` and `recvDone` are both 1.
- R2: While `recvReq` is 0, no completion pulse appears on either side, whatever the senders request. While no sender requests, `recvDone` stays 0. A waiting side stays blocked for as many cycles as its partner is absent.
- R3: In a transfer cycle `recvData` equals the data word of the chosen channel, and `recvIdx` gives that channel's number in plain binary.
- R4: When several senders request in the same cycle, the lowest index wins. The others receive no `sendDone` and complete in a later cycle once they are the lowest requester.
- R5: At most one bit of `sendDone` is 1 in any cycle, and `recvDone` is 1 exactly when some bit of `sendDone` is 1.
- R6: After reset the demonstration output `demoPins` is 0, and the first value the consumer takes is 0.
- R7: The demonstration producer moves its count on only after the consumer has taken the current value. Successive values seen on `demoPins` therefore step by +1 modulo 16, wrapping from 15 to 0.
- R8: After each take, the demonstration consumer idles for `DEMO_DELAY` cycles before it requests again. With the producer always ready, `demoPins` changes once every `DEMO_DELAY + 1` cycles.
- R9: Channel i's data occupies bits [i*W +: W] of `sendData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sendReq | input | NCH | Per-channel sender waiting flag |
| sendData | input | NCH*W | Sender words, channel i at [i*W +: W] |
| sendDone | output | NCH | One-cycle pulse to the sender whose word moved |
| recvReq | input | 1 | Receiver waiting flag |
| recvData | output | W | Word delivered in the transfer cycle |
| recvDone | output | 1 | One-cycle pulse to the receiver in the transfer cycle |
| recvIdx | output | IDXW | Channel number of the delivered word, valid with recvDone |
| demoPins | output | 4 | Count value last taken by the demonstration consumer |

## Verification
The hardest situation to reach from the ports is a sender that has lost the priority choice and must stay blocked, then win in a later cycle. The stimulus raises two senders together with the receiver waiting, checks that only the lower one completes, and then withdraws only the winner so that the held loser must complete next. Long one-sided waits are covered by holding a single sender for several cycles with the receiver absent before the receiver arrives. The demonstration timing is checked by measuring the spacing between changes on the pins and following the count through its wrap.

// File: rtl/rvzPkg.sv
package rvzPkg;

  typedef enum logic {
    CONS_RECV = 1'b0,
    CONS_HOLD = 1'b1
  } consStateT;

  // strobes from demo control to demo datapath
  typedef struct packed {
    logic xfer;
    logic waitLoad;
    logic waitDec;
  } demoStrobeT;

endpackage

// File: rtl/rvzSelectCtrl.sv
module rvzSelectCtrl #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned IDXW = 2
) (
  input  logic            recvReq,
  input  logic [NCH-1:0]  sendReq,
  output logic [NCH-1:0]  grant,
  output logic [IDXW-1:0] idx,
  output logic            fire
);

  logic found;

  always_comb begin
    grant = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (!found && sendReq[i]) begin
        grant[i] = recvReq;
        idx      = IDXW'(i);
        found    = 1'b1;
      end
    end
    fire = found & recvReq;
  end

endmodule

// File: rtl/rvzSelectPath.sv
module rvzSelectPath #(
  parameter int unsigned NCH = 4,
  parameter int unsigned W   = 8
) (
  input  logic [NCH*W-1:0] sendData,
  input  logic [NCH-1:0]   grant,
  output logic [W-1:0]     recvData
);

  logic [W-1:0] masked [NCH];

  for (genvar g = 0; g < NCH; g++) begin : gMask
    assign masked[g] = grant[g] ? sendData[g*W +: W] : '0;
  end

  always_comb begin
    recvData = '0;
    for (int i = 0; i < NCH; i++) begin
      recvData = recvData | masked[i];
    end
  end

endmodule

// File: rtl/rvzDemo.sv
module rvzDemo #(
  parameter int unsigned DELAY = 67088385,
  parameter int unsigned CW    = 4
) (
  input  logic          clk,
  input  logic          rstN,
  output logic [CW-1:0] pins
);
  import rvzPkg::*;

  localparam int unsigned DLY   = (DELAY < 1) ? 1 : DELAY;
  localparam int unsigned WAITW = (DLY < 2) ? 1 : $clog2(DLY);

  consStateT        state, stateNext;
  demoStrobeT       strb;
  logic [CW-1:0]    prodCount;
  logic [WAITW-1:0] waitCnt;
  logic             prodReq, consReq;

  // control
  assign prodReq = 1'b1;
  assign consReq = (state == CONS_RECV);

  always_comb begin
    strb.xfer     = prodReq & consReq;
    strb.waitLoad = strb.xfer;
    strb.waitDec  = (state == CONS_HOLD) && (waitCnt != '0);
    stateNext     = state;
    case (state)
      CONS_RECV: if (strb.xfer) stateNext = CONS_HOLD;
      CONS_HOLD: if (waitCnt == '0) stateNext = CONS_RECV;
      default:   stateNext = CONS_RECV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= CONS_RECV;
    else       state <= stateNext;
  end

  // datapath
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodCount <= '0;
      pins      <= '0;
      waitCnt   <= '0;
    end else begin
      if (strb.xfer) begin
        pins      <= prodCount;
        prodCount <= prodCount + CW'(1);
      end
      if (strb.waitLoad)     waitCnt <= WAITW'(DLY - 1);
      else if (strb.waitDec) waitCnt <= waitCnt - WAITW'(1);
    end
  end

endmodule

// File: rtl/rvzAltTop.sv
module rvzAltTop #(
  parameter int unsigned NCH        = 4,
  parameter int unsigned W          = 8,
  parameter int unsigned DEMO_DELAY = 67088385,
  parameter int unsigned IDXW       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH-1:0]   sendReq,
  input  logic [NCH*W-1:0] sendData,
  output logic [NCH-1:0]   sendDone,
  input  logic             recvReq,
  output logic [W-1:0]     recvData,
  output logic             recvDone,
  output logic [IDXW-1:0]  recvIdx,
  output logic [3:0]       demoPins
);

  logic [NCH-1:0] grant;
  logic           fire;

  rvzSelectCtrl #(.NCH(NCH), .IDXW(IDXW)) u_ctrl (
    .recvReq (recvReq),
    .sendReq (sendReq),
    .grant   (grant),
    .idx     (recvIdx),
    .fire    (fire)
  );

  rvzSelectPath #(.NCH(NCH), .W(W)) u_path (
    .sendData (sendData),
    .grant    (grant),
    .recvData (recvData)
  );

  rvzDemo #(.DELAY(DEMO_DELAY), .CW(4)) u_demo (
    .clk  (clk),
    .rstN (rstN),
    .pins (demoPins)
  );

  assign sendDone = grant;
  assign recvDone = fire;

endmodule

// File: rtl/rvzAltChk.sv
module rvzAltChk #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned IDXW = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic [NCH-1:0]  sendReq,
  input logic [NCH-1:0]  sendDone,
  input logic            recvReq,
  input logic            recvDone,
  input logic [IDXW-1:0] recvIdx,
  input logic [3:0]      demoPins
);

  for (genvar g = 0; g < NCH; g++) begin : gCh
    // R1
    send_needs_both_chk: assert property (@(posedge clk) disable iff (!rstN)
      sendDone[g] |-> (sendReq[g] && recvReq));
    // R3
    idx_matches_chk: assert property (@(posedge clk) disable iff (!rstN)
      sendDone[g] |-> (recvIdx == IDXW'(g)));
    if (g > 0) begin : gLow
      // R4
      lowest_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
        sendDone[g] |-> (sendReq[g-1:0] == '0));
    end
  end

  // R5
  one_winner_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sendDone));

  // R5
  recv_pairs_send_chk: assert property (@(posedge clk) disable iff (!rstN)
    recvDone == (sendDone != '0));

  // R2
  no_recv_no_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !recvReq |-> (sendDone == '0));

  // R7
  demo_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (demoPins != $past(demoPins)) |-> (demoPins == 4'($past(demoPins) + 4'd1)));

endmodule

bind rvzAltTop rvzAltChk #(.NCH(NCH), .IDXW(IDXW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sendReq  (sendReq),
  .sendDone (sendDone),
  .recvReq  (recvReq),
  .recvDone (recvDone),
  .recvIdx  (recvIdx),
  .demoPins (demoPins)
);

// File: tb/rvzAltTop_bench.sv
module rvzAltTop_bench;

  localparam int unsigned NCH   = 4;
  localparam int unsigned W     = 8;
  localparam int unsigned DELAY = 5;
  localparam int unsigned IDXW  = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [NCH-1:0]   sendReq = '0;
  logic [NCH*W-1:0] sendData = '0;
  logic [NCH-1:0]   sendDone;
  logic             recvReq = 1'b0;
  logic [W-1:0]     recvData;
  logic             recvDone;
  logic [IDXW-1:0]  recvIdx;
  logic [3:0]       demoPins;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rvzAltTop #(.NCH(NCH), .W(W), .DEMO_DELAY(DELAY)) u_rvzAltTop (
    .clk      (clk),
    .rstN     (rstN),
    .sendReq  (sendReq),
    .sendData (sendData),
    .sendDone (sendDone),
    .recvReq  (recvReq),
    .recvData (recvData),
    .recvDone (recvDone),
    .recvIdx  (recvIdx),
    .demoPins (demoPins)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {sendReq, recvReq, sendData, expSendDone, expRecvDone, expIdx, expData}
  localparam int VW = 4 + 1 + 32 + 4 + 1 + 2 + 8;
  localparam int NV = 8;
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'b0000, 1'b1, 32'hC75AA211, 4'b0000, 1'b0, 2'd0, 8'h00},
    {4'b0100, 1'b0, 32'hC75AA211, 4'b0000, 1'b0, 2'd0, 8'h00},
    {4'b0100, 1'b1, 32'hC75AA211, 4'b0100, 1'b1, 2'd2, 8'h5A},
    {4'b1010, 1'b1, 32'hC75AA211, 4'b0010, 1'b1, 2'd1, 8'hA2},
    {4'b1111, 1'b1, 32'hC75AA211, 4'b0001, 1'b1, 2'd0, 8'h11},
    {4'b1000, 1'b1, 32'hC75AA211, 4'b1000, 1'b1, 2'd3, 8'hC7},
    {4'b1100, 1'b1, 32'h3C00FF00, 4'b0100, 1'b1, 2'd2, 8'h00},
    {4'b1111, 1'b0, 32'hC75AA211, 4'b0000, 1'b0, 2'd0, 8'h00}
  };

  initial begin : watchdog
    #2_000_000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6 reset pins", 32'(demoPins), 32'h0);
    check("R2 reset idle recvDone", 32'(recvDone), 32'h0);
    rstN = 1'b1;

    // table walk: R1 R3 R4 R5 R9
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      @(negedge clk);
      sendReq  = e[VW-1 -: 4];
      recvReq  = e[VW-5];
      sendData = e[VW-6 -: 32];
      #1;
      check("R1 R4 table sendDone", 32'(sendDone), 32'(e[14:11]));
      check("R5 table recvDone", 32'(recvDone), 32'(e[10]));
      if (e[10]) begin
        check("R3 table recvIdx", 32'(recvIdx), 32'(e[9:8]));
        check("R3 R9 table recvData", 32'(recvData), 32'(e[7:0]));
      end
    end

    // R2: sender blocks while receiver absent
    @(negedge clk);
    sendData = 32'h44332211;
    sendReq  = 4'b0100;
    recvReq  = 1'b0;
    for (int c = 0; c < 3; c++) begin
      #1;
      check("R2 sender blocked", 32'(sendDone), 32'h0);
      @(negedge clk);
    end
    recvReq = 1'b1;
    #1;
    check("R1 late receiver completes", 32'(sendDone), 32'h4);
    check("R3 late receiver data", 32'(recvData), 32'h33);

    // R4: loser stays blocked, then wins
    @(negedge clk);
    sendReq = 4'b0011;
    #1;
    check("R4 lower wins", 32'(sendDone), 32'h1);
    @(negedge clk);
    sendReq = 4'b0010;
    #1;
    check("R4 held loser wins later", 32'(sendDone), 32'h2);
    check("R4 held loser idx", 32'(recvIdx), 32'h1);
    check("R4 held loser data", 32'(recvData), 32'h22);
    @(negedge clk);
    sendReq = '0;
    recvReq = 1'b0;

    // R7 R8: demo spacing and wrap
    begin
      logic [3:0] prev;
      int gap;
      bit seen;
      prev = demoPins;
      gap  = 0;
      seen = 1'b0;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        gap++;
        if (demoPins != prev) begin
          check("R7 demo step", 32'(demoPins), 32'(4'(prev + 4'd1)));
          if (seen) check("R8 demo spacing", 32'(gap), 32'(DELAY + 1));
          seen = 1'b1;
          prev = demoPins;
          gap  = 0;
        end
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule